// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Controller

This block throttles a link partner on a half-duplex Ethernet port when the local receive buffer cannot take more frames. It watches a buffer-full flag, the line's carrier sense and a receive-in-progress flag. It asserts a jam-transmit enable that the MAC transmit path turns into jam symbols on the wire. All durations are counted in bit times, using a one-cycle tick that the port's speed logic supplies: one tick per bit time at 10 or 100 Mbit/s.

Two styles can be selected. In carrier style the controller first defers for a normal inter-packet gap on an idle line. It then alternates fixed-length jam bursts with short backpressure gaps, so the partner never sees a gap long enough to start a frame. When the buffer drains, the current gap finishes and the port goes quiet. In collision style the controller jams only on top of a frame that the partner is already sending, which forces a collision. It releases as soon as the line is idle, then waits one normal gap before it can jam again.

Top module: `hdx_backpressure_jam`

## Requirements
- R1: While `rst` is high, and on the cycle after any clock edge that sampled `rst` high, `jam_en` is low.
- R2: In carrier style (`bp_mode`=0), after `buf_full` rises the block waits for an unbroken run of idle-line ticks before it jams. The run is 96 ticks when `ipg_short`=0 and 64 ticks when `ipg_short`=1. A tick sampled with `crs` high restarts the run. `jam_en` rises on the cycle after the clock edge that counts the last tick of the run.
- R3: Each carrier-style jam burst lasts exactly `JAM_BITS` ticks (default 32).
- R4: Between carrier-style bursts `jam_en` stays low for a backpressure gap set by `bp_gap_sel`: 0 gives 48 ticks, 1 gives 56, 2 gives 65 and 3 gives 72.
- R5: A burst already under way always completes. The next burst starts only if `buf_full` is still high when the gap ends; otherwise the port returns to idle and stays quiet. If `buf_full` falls during the deferral, no jam occurs.
- R6: In collision style (`bp_mode`=1), no jam starts unless `rx_active` and `buf_full` are both high at the same time. When they are, `jam_en` rises on the next cycle.
- R7: A collision-style jam holds while `crs` is high, whatever `buf_full` does. It drops on the cycle after `crs` is sampled low.
- R8: After a collision-style jam ends, no new jam starts until 96 ticks (`ipg_short`=0) or 64 ticks (`ipg_short`=1) have passed. The block is then ready to jam again on the next cycle.
- R9: Timers advance only on cycles with `bit_tick` high, so durations scale with the tick rate, and a burst can only end on a tick cycle.
- R10: `jam_en` never rises unless `buf_full` was high on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit time at the current port speed |
| buf_full | input | 1 | Receive buffer cannot accept more frames |
| crs | input | 1 | Carrier sense from the line |
| rx_active | input | 1 | A frame is being received |
| bp_mode | input | 1 | 0 = carrier style, 1 = collision style |
| bp_gap_sel | input | 2 | Backpressure gap code (48/56/65/72 ticks) |
| ipg_short | input | 1 | Normal gap: 0 = 96 ticks, 1 = 64 ticks |
| jam_en | output | 1 | Jam-transmit enable to the MAC transmit path |

## Verification
Every input passes through exactly one state register before it reaches `jam_en`. A collision-style start or release is therefore visible one cycle after the sampling edge. A carrier-style start is visible one cycle after the clock edge that counts the last deferral tick, which is N+1 cycles after `buf_full` rises on an idle line with a tick every cycle. Bursts and gaps last exactly their tick counts, measured between level changes. The bench drives on the falling edge and counts falling edges until `jam_en` reaches the expected level, then compares that count with the value worked out from these latencies. This includes a run with a tick every fourth cycle, where every duration is four times as long.

// File: rtl/hdx_bp_pkg.sv
package hdx_bp_pkg;

    localparam int BP_TW = 7;

    typedef enum logic [2:0] {
        BP_IDLE    = 3'd0,
        BP_DEFER   = 3'd1,
        BP_JAM     = 3'd2,
        BP_GAP     = 3'd3,
        BP_COLJAM  = 3'd4,
        BP_RECOVER = 3'd5
    } bp_state_e;

    typedef struct packed {
        logic       collision_style;
        logic [1:0] gap_code;
        logic       short_ipg;
    } bp_cfg_t;

    function automatic logic [BP_TW-1:0] bp_gap_ticks(input logic [1:0] code);
        case (code)
            2'd0:    return BP_TW'(48);
            2'd1:    return BP_TW'(56);
            2'd2:    return BP_TW'(65);
            default: return BP_TW'(72);
        endcase
    endfunction

    function automatic logic [BP_TW-1:0] bp_ipg_ticks(input logic short_sel);
        return short_sel ? BP_TW'(64) : BP_TW'(96);
    endfunction

endpackage

// File: rtl/bp_bit_timer.sv
module bp_bit_timer
    import hdx_bp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [BP_TW-1:0] limit,
    output logic             done
);

    logic [BP_TW-1:0] count;

    // done marks the tick that completes the programmed interval
    assign done = advance && (count == (limit - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (advance) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/bp_seq_fsm.sv
module bp_seq_fsm
    import hdx_bp_pkg::*;
#(
    parameter int JAM_BITS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             buf_full,
    input  logic             crs,
    input  logic             rx_active,
    input  bp_cfg_t          cfg,
    input  logic             t_done,
    output logic             t_clear,
    output logic             t_advance,
    output logic [BP_TW-1:0] t_limit,
    output bp_state_e        state
);

    localparam logic [BP_TW-1:0] JAM_LIMIT = BP_TW'(JAM_BITS);

    bp_state_e nxt;
    logic      hold_clear;

    always_comb begin
        nxt        = state;
        t_advance  = 1'b0;
        t_limit    = bp_ipg_ticks(cfg.short_ipg);
        hold_clear = 1'b0;
        case (state)
            BP_IDLE: begin
                if (buf_full) begin
                    if (cfg.collision_style) begin
                        if (rx_active) nxt = BP_COLJAM;
                    end else begin
                        nxt = BP_DEFER;
                    end
                end
            end
            BP_DEFER: begin
                // only an unbroken idle line counts toward the gap
                t_advance  = bit_tick && !crs;
                hold_clear = crs;
                if (!buf_full)   nxt = BP_IDLE;
                else if (t_done) nxt = BP_JAM;
            end
            BP_JAM: begin
                t_limit   = JAM_LIMIT;
                t_advance = bit_tick;
                if (t_done) nxt = BP_GAP;
            end
            BP_GAP: begin
                t_limit   = bp_gap_ticks(cfg.gap_code);
                t_advance = bit_tick;
                if (t_done) nxt = buf_full ? BP_JAM : BP_IDLE;
            end
            BP_COLJAM: begin
                if (!crs) nxt = BP_RECOVER;
            end
            BP_RECOVER: begin
                t_advance = bit_tick;
                if (t_done) nxt = BP_IDLE;
            end
            default: nxt = BP_IDLE;
        endcase
        t_clear = hold_clear || (nxt != state);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= BP_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/hdx_backpressure_jam.sv
module hdx_backpressure_jam
    import hdx_bp_pkg::*;
#(
    parameter int JAM_BITS = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       buf_full,
    input  logic       crs,
    input  logic       rx_active,
    input  logic       bp_mode,
    input  logic [1:0] bp_gap_sel,
    input  logic       ipg_short,
    output logic       jam_en
);

    bp_cfg_t          cfg;
    bp_state_e        seq_state;
    logic             t_clear;
    logic             t_advance;
    logic             t_done;
    logic [BP_TW-1:0] t_limit;

    assign cfg.collision_style = bp_mode;
    assign cfg.gap_code        = bp_gap_sel;
    assign cfg.short_ipg       = ipg_short;

    bp_seq_fsm #(.JAM_BITS(JAM_BITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .buf_full  (buf_full),
        .crs       (crs),
        .rx_active (rx_active),
        .cfg       (cfg),
        .t_done    (t_done),
        .t_clear   (t_clear),
        .t_advance (t_advance),
        .t_limit   (t_limit),
        .state     (seq_state)
    );

    bp_bit_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (t_clear),
        .advance (t_advance),
        .limit   (t_limit),
        .done    (t_done)
    );

    assign jam_en = (seq_state == BP_JAM) || (seq_state == BP_COLJAM);

endmodule

// File: rtl/hdx_backpressure_jam_chk.sv
module hdx_backpressure_jam_chk
    import hdx_bp_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bit_tick,
    input logic      buf_full,
    input logic      crs,
    input logic      rx_active,
    input logic      bp_mode,
    input logic      jam_en,
    input bp_state_e state
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !jam_en); // R1

    AST_JAM_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(jam_en) |-> $past(buf_full)); // R10

    AST_COL_NEEDS_RX: assert property (@(posedge clk) disable iff (rst)
        ($rose(jam_en) && $past(state) == BP_IDLE) |-> $past(rx_active && bp_mode)); // R6

    AST_COL_HOLDS_ON_CARRIER: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == BP_COLJAM && $past(crs)) |-> jam_en); // R7

    AST_COL_DROPS_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == BP_COLJAM && !$past(crs)) |-> !jam_en); // R7

    AST_BURST_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == BP_JAM && !jam_en) |-> $past(bit_tick)); // R9

    AST_REJAM_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == BP_GAP && state == BP_JAM) |-> $past(buf_full)); // R5

endmodule

bind hdx_backpressure_jam hdx_backpressure_jam_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .buf_full  (buf_full),
    .crs       (crs),
    .rx_active (rx_active),
    .bp_mode   (bp_mode),
    .jam_en    (jam_en),
    .state     (seq_state)
);

// File: tb/test_hdx_backpressure_jam.sv
`timescale 1ns/1ps
module test_hdx_backpressure_jam;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       buf_full = 1'b0;
    logic       crs = 1'b0;
    logic       rx_active = 1'b0;
    logic       bp_mode = 1'b0;
    logic [1:0] bp_gap_sel = 2'd0;
    logic       ipg_short = 1'b0;
    logic       jam_en;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_period = 1;
    int tdiv = 0;

    always #2.5 clk = ~clk;

    hdx_backpressure_jam i_hdx_backpressure_jam (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .buf_full   (buf_full),
        .crs        (crs),
        .rx_active  (rx_active),
        .bp_mode    (bp_mode),
        .bp_gap_sel (bp_gap_sel),
        .ipg_short  (ipg_short),
        .jam_en     (jam_en)
    );

    always @(negedge clk) begin
        if (tdiv >= tick_period - 1) begin
            tdiv     <= 0;
            bit_tick <= 1'b1;
        end else begin
            tdiv     <= tdiv + 1;
            bit_tick <= 1'b0;
        end
    end

    // gap code, short ipg, expected defer count, expected gap length
    localparam int VEC [4][4] = '{
        '{0, 0, 97, 48},
        '{1, 1, 65, 56},
        '{2, 0, 97, 65},
        '{3, 1, 65, 72}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_for(input logic lvl, input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (jam_en !== lvl && n < lim);
    endtask

    task automatic count_high(input int cycles, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (jam_en !== 1'b0) n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        buf_full = 1'b0;
        crs = 1'b0;
        rx_active = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int n;
        do_reset();
        check("R1 reset state", int'(jam_en), 0);

        // table walk over carrier-style gap and deferral settings
        for (int i = 0; i < 4; i++) begin
            do_reset();
            bp_mode    = 1'b0;
            bp_gap_sel = 2'(VEC[i][0]);
            ipg_short  = VEC[i][1][0];
            @(negedge clk);
            buf_full = 1'b1;
            wait_for(1'b1, 400, n);
            check("R2 deferral before first burst", n, VEC[i][2]);
            wait_for(1'b0, 200, n);
            check("R3 burst length", n, 32);
            wait_for(1'b1, 200, n);
            check("R4 backpressure gap", n, VEC[i][3]);
            buf_full = 1'b0;
            wait_for(1'b0, 200, n);
            check("R5 burst completes after release", n, 32);
            count_high(150, n);
            check("R5 quiet after release", n, 0);
        end

        // R2: carrier on the line restarts the deferral
        do_reset();
        bp_mode = 1'b0; ipg_short = 1'b0; bp_gap_sel = 2'd0;
        @(negedge clk);
        buf_full = 1'b1;
        repeat (40) @(negedge clk);
        crs = 1'b1;
        repeat (10) @(negedge clk);
        crs = 1'b0;
        wait_for(1'b1, 400, n);
        check("R2 deferral restart on carrier", n, 96);

        // R5: buffer drains during deferral, no jam at all
        do_reset();
        @(negedge clk);
        buf_full = 1'b1;
        repeat (30) @(negedge clk);
        buf_full = 1'b0;
        count_high(150, n);
        check("R5 abort during deferral", n, 0);

        // R9: slower tick scales every duration
        do_reset();
        tick_period = 4;
        bp_gap_sel = 2'd0; ipg_short = 1'b0;
        @(negedge clk);
        buf_full = 1'b1;
        wait_for(1'b1, 1000, n);
        wait_for(1'b0, 400, n);
        check("R9 burst at quarter tick rate", n, 128);
        wait_for(1'b1, 400, n);
        check("R9 gap at quarter tick rate", n, 192);
        buf_full = 1'b0;
        tick_period = 1;

        // collision style
        do_reset();
        bp_mode = 1'b1; ipg_short = 1'b1;
        @(negedge clk);
        buf_full = 1'b1;
        crs = 1'b1;
        count_high(150, n);
        check("R6 no jam without reception", n, 0);
        rx_active = 1'b1;
        wait_for(1'b1, 50, n);
        check("R6 jam latency on reception", n, 1);
        buf_full = 1'b0;
        repeat (20) @(negedge clk);
        check("R7 jam holds while carrier present", int'(jam_en), 1);
        crs = 1'b0;
        rx_active = 1'b0;
        wait_for(1'b0, 50, n);
        check("R7 release latency on idle line", n, 1);
        crs = 1'b1; rx_active = 1'b1; buf_full = 1'b1;
        wait_for(1'b1, 300, n);
        check("R8 rearm after normal gap", n, 65);
        crs = 1'b0; rx_active = 1'b0; buf_full = 1'b0;

        // R1: reset in the middle of a burst
        do_reset();
        bp_mode = 1'b0; ipg_short = 1'b1;
        @(negedge clk);
        buf_full = 1'b1;
        wait_for(1'b1, 200, n);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears active jam", int'(jam_en), 0);
        rst = 1'b0;
        buf_full = 1'b0;
        repeat (5) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule